// File: doc/BRIEF.md
# Keypad Combination Lock Controller

This block is the controller of a four-digit combination lock driven by a keypad. The keypad presents one BCD digit at a time on a parallel bus, and the user confirms each digit with an Enter button. The raw digit bus and the Enter button are asynchronous to the clock. Both pass through two-flop synchronizers. Enter is then filtered by a majority-vote debouncer and reduced to a single-cycle pulse, so that one press confirms exactly one digit.

Each confirmed digit is latched and checked straight away against a fixed code table. The table is indexed by the current digit position. A correct digit moves the position forward. A wrong digit sends entry back to the first digit and counts one failed attempt. A fully correct code opens the lock, and it stays open until reset. After a set number of failed attempts the lock blocks all input for a lockout period, given in clock cycles. When that period ends, the failure count is cleared.

The outputs are the open state, its complement (the locked state), a lockout flag, and the current digit position for a progress display.

Top module: `combo_lock_ctrl`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the controller returns to its start state: `unlock`=0, `lockout`=0, `locked`=1 and `digit_pos`=0, with the failure count cleared.
- R2: The code is held in the parameter `CODE`, which packs one 4-bit digit per position. Bits [3:0] hold the digit expected first. The default value 16'h9173 gives the sequence 3, 7, 1, 9.
- R3: A confirmed digit that equals the table entry at positions 0 to 2 increases `digit_pos` by exactly one.
- R4: A confirmed digit that equals the table entry at the last position (3) sets `unlock`=1 and `locked`=0. `unlock` then stays high, and further digits have no effect until reset.
- R5: A confirmed digit that differs from the table entry returns `digit_pos` to 0 and counts one failed attempt.
- R6: The failed attempt that brings the count to `MAX_FAILS` (default 3) raises `lockout`. Digits confirmed while `lockout` is high are ignored, and `digit_pos` stays 0.
- R7: `lockout` stays high for exactly `LOCKOUT_CYCLES` consecutive clock cycles and then falls. When it falls, the failure count is cleared, so another `MAX_FAILS` failures are needed before the next lockout.
- R8: A high level on `enter_btn` that lasts fewer than (`DEB_LEN`+1)/2 clock cycles confirms nothing. A press that bounces on its edges confirms exactly one digit.
- R9: A reset during code entry or during lockout returns the controller to the R1 state, and it clears any failed attempts already counted.
- R10: `unlock` and `lockout` are never high at the same time, and `locked` is always the inverse of `unlock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| digit_in | input | DIGIT_W (4) | Keypad BCD digit, asynchronous |
| enter_btn | input | 1 | Enter button level, asynchronous, may bounce |
| unlock | output | 1 | High once the full code has been entered correctly |
| locked | output | 1 | Inverse of unlock |
| lockout | output | 1 | High for the whole lockout period |
| digit_pos | output | POS_W (2) | Index of the next digit expected |

## Verification
The assertions assume that `digit_in` holds steady from a few cycles before Enter is pressed until after the press is released. This lets the synchronized digit match the confirmed digit. They also assume that reset, once asserted, is held for at least two cycles. The stimulus meets both assumptions. It sets each digit three cycles before raising Enter, holds it for the whole press and release, and holds reset low for three cycles. The random presses mix correct and wrong digits, which drives the controller through normal entry, opening and lockout. Separate directed sequences cover glitches, bounced presses and reset during entry or lockout.

// File: rtl/lock_pkg.sv
// Package: shared types for the combination lock controller.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package lock_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WAIT    = 3'd1,
        ST_CHECK   = 3'd2,
        ST_OPEN    = 3'd3,
        ST_BLOCKED = 3'd4
    } lock_state_t;

    // Control word sent from the FSM to the datapath
    typedef struct packed {
        logic load_digit;
        logic inc_pos;
        logic clr_pos;
        logic inc_fail;
        logic clr_fail;
        logic start_timer;
    } lock_ctrl_t;

    // Majority threshold for an odd-length debounce window
    function automatic int unsigned majority_min(input int unsigned len);
        return (len + 1) / 2;
    endfunction

endpackage

// File: rtl/lock_input_cond.sv
// Module: input conditioning for the keypad.
// Synchronizes the digit bus and the Enter level, debounces Enter with a
// majority vote over a sliding window and emits a one-cycle pulse on each
// debounced rising edge.
// Assumes: DEB_LEN is odd and >= 3; the digit is stable around a press.
module lock_input_cond
    import lock_pkg::*;
#(
    parameter int unsigned DIGIT_W     = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DEB_LEN     = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIGIT_W-1:0] digit_raw,
    input  logic               enter_raw,
    output logic [DIGIT_W-1:0] digit_sync,
    output logic               enter_pulse
);

    localparam int unsigned CNT_W   = $clog2(DEB_LEN + 1);
    localparam int unsigned MAJ_MIN = majority_min(DEB_LEN);

    logic [DIGIT_W-1:0] dig_stage [SYNC_STAGES];
    logic               ent_stage [SYNC_STAGES];
    logic [DEB_LEN-1:0] window_q;
    logic [CNT_W-1:0]   ones_cnt;
    logic               vote;
    logic               level_q;
    logic               pulse_q;

    // Synchronizer chains, one stage per generate iteration
    for (genvar gs = 0; gs < SYNC_STAGES; gs++) begin : g_sync
        if (gs == 0) begin : g_first
            // Purpose: first capture flop of each synchronizer
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dig_stage[gs] <= '0;
                    ent_stage[gs] <= 1'b0;
                end else begin
                    dig_stage[gs] <= digit_raw;
                    ent_stage[gs] <= enter_raw;
                end
            end
        end else begin : g_next
            // Purpose: further metastability settling stages
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dig_stage[gs] <= '0;
                    ent_stage[gs] <= 1'b0;
                end else begin
                    dig_stage[gs] <= dig_stage[gs-1];
                    ent_stage[gs] <= ent_stage[gs-1];
                end
            end
        end
    end

    assign digit_sync = dig_stage[SYNC_STAGES-1];

    // Purpose: slide the synchronized Enter level into the vote window
    always_ff @(posedge clk) begin
        if (!rst_n) window_q <= '0;
        else        window_q <= {window_q[DEB_LEN-2:0], ent_stage[SYNC_STAGES-1]};
    end

    // Purpose: count high samples in the window
    always_comb begin
        ones_cnt = '0;
        for (int i = 0; i < DEB_LEN; i++) begin
            ones_cnt = ones_cnt + CNT_W'(window_q[i]);
        end
    end

    assign vote = (ones_cnt >= CNT_W'(MAJ_MIN));

    // Purpose: hold the debounced level and flag its rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            level_q <= vote;
            pulse_q <= vote & ~level_q;
        end
    end

    assign enter_pulse = pulse_q;

endmodule

// File: rtl/lock_datapath.sv
// Module: datapath of the combination lock.
// Holds the latched digit, the code table, the comparator, the position
// and failure counters and the lockout down-counter. All updates are
// commanded by the control word from the FSM.
// Assumes: CODE_LEN >= 2, MAX_FAILS >= 1, LOCKOUT_CYCLES >= 1.
module lock_datapath
    import lock_pkg::*;
#(
    parameter int unsigned DIGIT_W        = 4,
    parameter int unsigned CODE_LEN       = 4,
    parameter logic [CODE_LEN*DIGIT_W-1:0] CODE = 16'h9173,
    parameter int unsigned MAX_FAILS      = 3,
    parameter int unsigned LOCKOUT_CYCLES = 1500000,
    localparam int unsigned POS_W         = $clog2(CODE_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  lock_ctrl_t         ctrl,
    input  logic [DIGIT_W-1:0] digit_sync,
    output logic               match,
    output logic               at_last_pos,
    output logic               fails_at_limit,
    output logic               timer_done,
    output logic [POS_W-1:0]   pos
);

    localparam int unsigned FAIL_W = $clog2(MAX_FAILS + 1);
    localparam int unsigned TMR_W  = $clog2(LOCKOUT_CYCLES + 1);

    logic [DIGIT_W-1:0] code_tab [CODE_LEN];
    logic [DIGIT_W-1:0] digit_q;
    logic [POS_W-1:0]   pos_q;
    logic [FAIL_W-1:0]  fail_q;
    logic [TMR_W-1:0]   timer_q;

    // Code table: one entry per position, sliced from the packed parameter
    for (genvar gi = 0; gi < CODE_LEN; gi++) begin : g_tab
        assign code_tab[gi] = CODE[gi*DIGIT_W +: DIGIT_W];
    end

    // Purpose: latch the confirmed digit
    always_ff @(posedge clk) begin
        if (!rst_n)               digit_q <= '0;
        else if (ctrl.load_digit) digit_q <= digit_sync;
    end

    // Purpose: track the position of the next expected digit
    always_ff @(posedge clk) begin
        if (!rst_n)            pos_q <= '0;
        else if (ctrl.clr_pos) pos_q <= '0;
        else if (ctrl.inc_pos) pos_q <= pos_q + 1'b1;
    end

    // Purpose: count failed attempts
    always_ff @(posedge clk) begin
        if (!rst_n)             fail_q <= '0;
        else if (ctrl.clr_fail) fail_q <= '0;
        else if (ctrl.inc_fail) fail_q <= fail_q + 1'b1;
    end

    // Purpose: lockout down-counter, loaded on entry and run to zero
    always_ff @(posedge clk) begin
        if (!rst_n)                timer_q <= '0;
        else if (ctrl.start_timer) timer_q <= TMR_W'(LOCKOUT_CYCLES - 1);
        else if (timer_q != '0)    timer_q <= timer_q - 1'b1;
    end

    assign match          = (digit_q == code_tab[pos_q]);
    assign at_last_pos    = (pos_q == POS_W'(CODE_LEN - 1));
    assign fails_at_limit = (fail_q == FAIL_W'(MAX_FAILS - 1));
    assign timer_done     = (timer_q == '0);
    assign pos            = pos_q;

endmodule

// File: rtl/lock_fsm.sv
// Module: control FSM of the combination lock.
// Sequences idle, digit wait, digit check, open and lockout, and drives
// the datapath control word. Status flags are registered state decodes.
// Assumes: enter_pulse lasts one cycle; datapath flags are valid in CHECK.
module lock_fsm
    import lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enter_pulse,
    input  logic       match,
    input  logic       at_last_pos,
    input  logic       fails_at_limit,
    input  logic       timer_done,
    output lock_ctrl_t ctrl,
    output logic       is_open,
    output logic       is_blocked
);

    lock_state_t state_q, state_d;

    // Purpose: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: next-state and control word decode
    always_comb begin
        state_d = state_q;
        ctrl    = '0;
        unique case (state_q)
            ST_IDLE: begin
                ctrl.clr_pos = 1'b1;
                state_d      = ST_WAIT;
            end
            ST_WAIT: begin
                if (enter_pulse) begin
                    ctrl.load_digit = 1'b1;
                    state_d         = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (match) begin
                    if (at_last_pos) begin
                        state_d = ST_OPEN;
                    end else begin
                        ctrl.inc_pos = 1'b1;
                        state_d      = ST_WAIT;
                    end
                end else begin
                    ctrl.clr_pos  = 1'b1;
                    ctrl.inc_fail = 1'b1;
                    if (fails_at_limit) begin
                        ctrl.start_timer = 1'b1;
                        state_d          = ST_BLOCKED;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_OPEN: begin
                state_d = ST_OPEN;
            end
            ST_BLOCKED: begin
                if (timer_done) begin
                    ctrl.clr_fail = 1'b1;
                    state_d       = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign is_open    = (state_q == ST_OPEN);
    assign is_blocked = (state_q == ST_BLOCKED);

endmodule

// File: rtl/combo_lock_ctrl.sv
// Module: top of the keypad combination lock controller.
// Joins input conditioning, datapath and FSM.
// Assumes: single clock, synchronous active-low reset held >= 2 cycles.
module combo_lock_ctrl
    import lock_pkg::*;
#(
    parameter int unsigned DIGIT_W        = 4,
    parameter int unsigned CODE_LEN       = 4,
    parameter logic [CODE_LEN*DIGIT_W-1:0] CODE = 16'h9173,
    parameter int unsigned MAX_FAILS      = 3,
    parameter int unsigned LOCKOUT_CYCLES = 1500000,
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned DEB_LEN        = 5,
    localparam int unsigned POS_W         = $clog2(CODE_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIGIT_W-1:0] digit_in,
    input  logic               enter_btn,
    output logic               unlock,
    output logic               locked,
    output logic               lockout,
    output logic [POS_W-1:0]   digit_pos
);

    logic [DIGIT_W-1:0] digit_sync;
    logic               enter_pulse;
    lock_ctrl_t         ctrl;
    logic               match;
    logic               at_last_pos;
    logic               fails_at_limit;
    logic               timer_done;
    logic               is_open;
    logic               is_blocked;

    lock_input_cond #(
        .DIGIT_W    (DIGIT_W),
        .SYNC_STAGES(SYNC_STAGES),
        .DEB_LEN    (DEB_LEN)
    ) u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .digit_raw  (digit_in),
        .enter_raw  (enter_btn),
        .digit_sync (digit_sync),
        .enter_pulse(enter_pulse)
    );

    lock_datapath #(
        .DIGIT_W       (DIGIT_W),
        .CODE_LEN      (CODE_LEN),
        .CODE          (CODE),
        .MAX_FAILS     (MAX_FAILS),
        .LOCKOUT_CYCLES(LOCKOUT_CYCLES)
    ) u_dp (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl          (ctrl),
        .digit_sync    (digit_sync),
        .match         (match),
        .at_last_pos   (at_last_pos),
        .fails_at_limit(fails_at_limit),
        .timer_done    (timer_done),
        .pos           (digit_pos)
    );

    lock_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .enter_pulse   (enter_pulse),
        .match         (match),
        .at_last_pos   (at_last_pos),
        .fails_at_limit(fails_at_limit),
        .timer_done    (timer_done),
        .ctrl          (ctrl),
        .is_open       (is_open),
        .is_blocked    (is_blocked)
    );

    assign unlock  = is_open;
    assign locked  = ~is_open;
    assign lockout = is_blocked;

endmodule

// File: rtl/lock_checker.sv
// Module: property checker for combo_lock_ctrl, attached by bind.
// Assumes: reset is held low for at least two cycles.
module lock_checker #(
    parameter int unsigned POS_W          = 2,
    parameter int unsigned LOCKOUT_CYCLES = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             unlock,
    input logic             locked,
    input logic             lockout,
    input logic [POS_W-1:0] digit_pos,
    input logic             enter_pulse
);

    int unsigned lo_run;

    // Purpose: count consecutive cycles with lockout high
    always_ff @(posedge clk) begin
        if (!rst_n)       lo_run <= 0;
        else if (lockout) lo_run <= lo_run + 1;
        else              lo_run <= 0;
    end

    assert_open_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        unlock |=> unlock);

    assert_pos_frozen_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock && $past(unlock)) |-> $stable(digit_pos));

    assert_pos_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(digit_pos) |-> (digit_pos == $past(digit_pos) + 1'b1 || digit_pos == '0));

    assert_pos_zero_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |-> digit_pos == '0);

    assert_lockout_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lo_run <= LOCKOUT_CYCLES);

    assert_lockout_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lockout && $past(lockout)) |-> lo_run == LOCKOUT_CYCLES);

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        enter_pulse |=> !enter_pulse);

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({unlock, lockout}) && (locked != unlock));

endmodule

bind combo_lock_ctrl lock_checker #(
    .POS_W         (POS_W),
    .LOCKOUT_CYCLES(LOCKOUT_CYCLES)
) u_lock_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .unlock     (unlock),
    .locked     (locked),
    .lockout    (lockout),
    .digit_pos  (digit_pos),
    .enter_pulse(enter_pulse)
);

// File: tb/test_combo_lock_ctrl.sv
// Bench: random and directed keypad sequences checked against a bench model.
module test_combo_lock_ctrl;

    localparam int unsigned LOCK_N = 80;
    localparam logic [15:0] CODE   = 16'h9173;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] digit_in = 4'd0;
    logic       enter_btn = 1'b0;
    logic       unlock, locked, lockout;
    logic [1:0] digit_pos;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int m_pos = 0;
    int m_fails = 0;
    bit m_open = 1'b0;
    bit m_block = 1'b0;

    int run_len = 0;
    int last_run = 0;

    always #2 clk = ~clk;

    combo_lock_ctrl #(
        .LOCKOUT_CYCLES(LOCK_N),
        .DEB_LEN       (5)
    ) i_combo_lock_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .digit_in (digit_in),
        .enter_btn(enter_btn),
        .unlock   (unlock),
        .locked   (locked),
        .lockout  (lockout),
        .digit_pos(digit_pos)
    );

    // Length of each lockout run, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst_n) run_len <= 0;
        else if (lockout) run_len <= run_len + 1;
        else if (run_len > 0) begin
            last_run <= run_len;
            run_len  <= 0;
        end
    end

    function automatic logic [3:0] code_at(input int p);
        return CODE[p*4 +: 4];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        check(digit_pos == 2'(m_pos), {req, " digit_pos"}, digit_pos, m_pos);
        check(unlock == m_open, {req, " unlock"}, unlock, m_open);
        check(lockout == m_block, {req, " lockout"}, lockout, m_block);
        check(locked == !m_open && !(unlock && lockout), "R10 locked/exclusive",
              {locked, unlock, lockout}, {!m_open, m_open, m_block});
    endtask

    task automatic model_digit(input logic [3:0] d);
        if (m_open || m_block) return;
        if (d == code_at(m_pos)) begin
            if (m_pos == 3) m_open = 1'b1;
            else            m_pos++;
        end else begin
            m_pos = 0;
            m_fails++;
            if (m_fails == 3) m_block = 1'b1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        enter_btn = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_pos = 0; m_fails = 0; m_open = 1'b0; m_block = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic press(input logic [3:0] d);
        @(negedge clk);
        digit_in = d;
        repeat (3) @(negedge clk);
        enter_btn = 1'b1;
        repeat (10) @(negedge clk);
        enter_btn = 1'b0;
        repeat (12) @(negedge clk);
        model_digit(d);
    endtask

    task automatic bounce_press(input logic [3:0] d);
        logic [5:0] pat;
        @(negedge clk);
        digit_in = d;
        repeat (3) @(negedge clk);
        pat = 6'b101101;
        for (int i = 5; i >= 0; i--) begin
            enter_btn = pat[i];
            @(negedge clk);
        end
        enter_btn = 1'b1;
        repeat (10) @(negedge clk);
        enter_btn = 1'b0; @(negedge clk);
        enter_btn = 1'b1; @(negedge clk);
        enter_btn = 1'b0;
        repeat (14) @(negedge clk);
        model_digit(d);
    endtask

    task automatic finish_lockout(input string req);
        int n = 0;
        while (lockout && n < 500) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        check(last_run == LOCK_N, {req, " lockout length"}, last_run, LOCK_N);
        m_block = 1'b0;
        m_fails = 0;
        m_pos = 0;
        check_state({req, " after lockout"});
    endtask

    // Main stimulus
    initial begin
        int seed;
        logic [3:0] d;
        seed = $urandom(32'd20240);
        do_reset();
        check_state("R1 reset");

        // R2/R3/R4: default code 3-7-1-9
        press(4'd3); check_state("R3 pos0 ok");
        press(4'd7); check_state("R3 pos1 ok");
        press(4'd1); check_state("R3 pos2 ok");
        press(4'd9); check_state("R2 R4 open");
        press(4'd5); check_state("R4 ignored while open");
        do_reset(); check_state("R1 reset after open");

        // R5: mismatch restarts
        press(4'd3); press(4'd8); check_state("R5 mismatch");

        // R8: short glitch ignored, then a bounced press counts once
        @(negedge clk); digit_in = 4'd3; repeat (3) @(negedge clk);
        enter_btn = 1'b1; repeat (2) @(negedge clk); enter_btn = 1'b0;
        repeat (20) @(negedge clk);
        check_state("R8 glitch ignored");
        bounce_press(4'd3); check_state("R8 bounced press once");

        // R9: reset mid-entry clears position and the earlier failure
        do_reset(); check_state("R9 reset during entry");
        press(4'd0); press(4'd0); check_state("R9 failures cleared by reset");
        press(4'd0); check_state("R6 third failure locks");
        press(4'd3); check_state("R6 digit ignored in lockout");
        finish_lockout("R7");

        // R7: failure count cleared after expiry
        press(4'd0); press(4'd0); check_state("R7 count cleared");
        press(4'd0); check_state("R6 locks again");
        do_reset(); check_state("R9 reset during lockout");
        press(4'd3); press(4'd7); press(4'd1); press(4'd9);
        check_state("R2 open after lockout reset");
        do_reset();

        // Random digits, biased toward the expected one
        for (int it = 0; it < 90; it++) begin
            if ($urandom % 3 != 0) d = code_at(m_pos);
            else                   d = 4'($urandom % 10);
            press(d);
            check_state("R3 R5 random");
            if (m_block) finish_lockout("R7 random");
            if (m_open) do_reset();
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule